// File: doc/BRIEF.md
# Sigma-Delta Threshold Comparator Filter

This block takes the one-bit stream of a sigma-delta modulator together with its clock and recovers a coarse multi-bit value from it. Each rising edge of the modulator clock delivers one bit. The bit is weighted as a signed step and fed into a cascade of integrators. Every R bits, where R is the oversampling ratio, the integrator result passes through matching difference stages, which gives one decimated sample. The order of the cascade is picked by a filter-type input. The fast type is a second-order cascade with doubled input weighting, so it has a higher gain.

Each decimated sample is compared against two upper limits, two lower limits and one crossing level. The raw compare results go through a noise-blanking qualifier. A qualified flag only changes after its raw condition has held a different value for a programmable number of consecutive samples. The over-value and under-value flags suit fast protection. The crossing output is a level that can be timed externally to measure duty cycle or frequency.

The modulator clock is asynchronous to the system clock and must run slower than half the system clock rate. Configuration inputs are changed only while reset is held.

Top module: `sd_threshold_filter`

## Requirements
- R1: The sample is the convolution of the weighted bits with N cascaded boxcars of length R, taken at the last bit of each group of R bits. Every filter stage starts from zero at reset, and each rising modulator clock edge delivers one bit.
- R2: filtType selects the order N. 1 selects first order, 2 selects second order, 3 selects third order, and 0 selects the fast type.
- R3: In the fast type (filtType 0), N is 2 and a bit of 1 weighs +2 while a bit of 0 weighs −2. In all other types a bit of 1 weighs +1 and a bit of 0 weighs −1.
- R4: osrCode values 0 to 31 give R = osrCode + 1. sampleValid pulses for exactly one system cycle per R bits, and sample only changes on that cycle.
- R5: The raw over-value event of upper comparator i is true when the sample, as a signed value, is strictly greater than hiLim[i]. overFlag[i] carries the qualified result.
- R6: The raw under-value event of lower comparator i is true when the sample is strictly less than loLim[i]. A sample equal to the limit raises no event. underFlag[i] carries the qualified result.
- R7: The raw crossing event is true when the sample is strictly greater than crossLim. crossLevel carries the qualified result as a level.
- R8: With K = qualCode + 1 (1 to 16), a qualified output takes its raw value only after the raw value has differed from it on K consecutive samples. A sample on which raw equals the output restarts the count.
- R9: While rst is high, sample is 0, sampleValid is 0 and all flags are 0.
- R10: Flags change only on the system cycle that directly follows a sampleValid pulse.
- R11: The largest third-order result at R = 32 is ±32768, and it is represented without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| modClk | input | 1 | Modulator bit clock, asynchronous |
| modData | input | 1 | Modulator bitstream |
| filtType | input | 2 | Filter type select (R2) |
| osrCode | input | 5 | Oversampling ratio minus one |
| qualCode | input | 4 | Qualifier persistence minus one |
| hiLim | input | 2x18 | Signed upper limits, one per comparator |
| loLim | input | 2x18 | Signed lower limits, one per comparator |
| crossLim | input | 18 | Signed crossing level |
| sample | output | 18 | Signed decimated result |
| sampleValid | output | 1 | One-cycle strobe for a new sample |
| overFlag | output | 2 | Qualified over-value flags |
| underFlag | output | 2 | Qualified under-value flags |
| crossLevel | output | 1 | Qualified crossing level |

## Verification
The hardest conditions to reach from the ports are samples that land exactly on a limit, and qualifier runs that break one sample short of the persistence count. The first-order type at R = 16 makes each sample equal to 2k − 16, where k is the number of ones sent in that group. The stimulus picks k directly to hit each limit, to step across it, and to build runs of chosen length, and it repeats the sequence with persistence 1 and 3. The third-order extremes are reached with long runs of all ones and all zeros at R = 32.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

  typedef enum logic [1:0] {
    FiltFast  = 2'd0,
    FiltSinc1 = 2'd1,
    FiltSinc2 = 2'd2,
    FiltSinc3 = 2'd3
  } filt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic bitStb;   // a modulator bit is present this cycle
    logic decStb;   // this bit closes a decimation group
    logic bitVal;   // the bit value
  } sdcf_stb_t;

  localparam int NumStage = 3;

endpackage

// File: rtl/sdcf_ctrl.sv
module sdcf_ctrl
  import sdcf_pkg::*;
#(
  parameter int OsrW   = 5,
  parameter int QualW  = 4,
  parameter int NumEvt = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modClk,
  input  logic              modData,
  input  logic [OsrW-1:0]   osrCode,
  input  logic [QualW-1:0]  qualCode,
  input  logic              sampleValid,
  input  logic [NumEvt-1:0] rawEvt,
  output sdcf_stb_t         stb,
  output logic [NumEvt-1:0] evtFlag
);

  localparam int PipeD = 3;

  logic [PipeD-1:0] clkPipe;
  logic [PipeD-2:0] datPipe;
  logic [OsrW-1:0]  bitCnt;
  logic             edgeSeen;
  logic             lastBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      clkPipe <= '0;
      datPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[PipeD-2:0], modClk};
      datPipe <= {datPipe[PipeD-3:0], modData};
    end
  end

  assign edgeSeen = clkPipe[PipeD-2] & ~clkPipe[PipeD-1];
  assign lastBit  = (bitCnt == osrCode);

  always_ff @(posedge clk) begin
    if (rst)
      bitCnt <= '0;
    else if (edgeSeen)
      bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end

  always_comb begin
    stb.bitStb = edgeSeen;
    stb.decStb = edgeSeen & lastBit;
    stb.bitVal = datPipe[PipeD-2];
  end

  // noise-blanking qualifiers, one per comparator event
  for (genvar e = 0; e < NumEvt; e++) begin : g_qual
    logic [QualW-1:0] runCnt;
    logic             flagQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        runCnt <= '0;
        flagQ  <= 1'b0;
      end else if (sampleValid) begin
        if (rawEvt[e] == flagQ) begin
          runCnt <= '0;
        end else if (runCnt == qualCode) begin
          flagQ  <= rawEvt[e];
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
    end
    assign evtFlag[e] = flagQ;

    a_r8_run_bound: assert property (@(posedge clk) disable iff (rst)
      runCnt <= qualCode);
  end

  a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= osrCode);

  a_r8_unit_follow: assert property (@(posedge clk) disable iff (rst)
    ($past(sampleValid) && $past(qualCode) == '0) |-> evtFlag == $past(rawEvt));

  a_r10_flags_after_valid: assert property (@(posedge clk) disable iff (rst)
    !$stable(evtFlag) |-> $past(sampleValid));

endmodule

// File: rtl/sdcf_datapath.sv
module sdcf_datapath
  import sdcf_pkg::*;
#(
  parameter int AccW  = 18,
  parameter int NumHi = 2,
  parameter int NumLo = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  sdcf_stb_t                   stb,
  input  filt_e                       filtType,
  input  logic [NumHi-1:0][AccW-1:0]  hiLim,
  input  logic [NumLo-1:0][AccW-1:0]  loLim,
  input  logic [AccW-1:0]             crossLim,
  output logic signed [AccW-1:0]      sample,
  output logic                        sampleValid,
  output logic [NumHi+NumLo:0]        rawEvt
);

  localparam int LoBase = NumHi;
  localparam int CrIdx  = NumHi + NumLo;

  logic signed [AccW-1:0] integ   [NumStage];
  logic signed [AccW-1:0] intNext [NumStage];
  logic signed [AccW-1:0] combDly [NumStage];
  logic signed [AccW-1:0] combIn  [NumStage];
  logic signed [AccW-1:0] combOut [NumStage];
  logic signed [AccW-1:0] stepMag;
  logic signed [AccW-1:0] xIn;
  logic signed [AccW-1:0] tap;
  logic signed [AccW-1:0] result;

  // input weighting
  always_comb begin
    stepMag = (filtType == FiltFast) ? AccW'(2) : AccW'(1);
    xIn     = stb.bitVal ? stepMag : -stepMag;
  end

  // integrator chain, each stage sees the current bit
  always_comb begin
    intNext[0] = integ[0] + xIn;
    for (int s = 1; s < NumStage; s++)
      intNext[s] = integ[s] + intNext[s-1];
  end

  // pick the integrator of the chosen order
  always_comb begin
    unique case (filtType)
      FiltSinc1: tap = intNext[0];
      FiltSinc3: tap = intNext[2];
      default:   tap = intNext[1];
    endcase
  end

  // difference chain at the decimated rate
  always_comb begin
    combIn[0]  = tap;
    combOut[0] = tap - combDly[0];
    for (int s = 1; s < NumStage; s++) begin
      combIn[s]  = combOut[s-1];
      combOut[s] = combOut[s-1] - combDly[s];
    end
  end

  always_comb begin
    unique case (filtType)
      FiltSinc1: result = combOut[0];
      FiltSinc3: result = combOut[2];
      default:   result = combOut[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NumStage; s++) begin
        integ[s]   <= '0;
        combDly[s] <= '0;
      end
      sample      <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= stb.decStb;
      if (stb.bitStb) begin
        for (int s = 0; s < NumStage; s++)
          integ[s] <= intNext[s];
      end
      if (stb.decStb) begin
        for (int s = 0; s < NumStage; s++)
          combDly[s] <= combIn[s];
        sample <= result;
      end
    end
  end

  // threshold comparators
  for (genvar h = 0; h < NumHi; h++) begin : g_hi
    assign rawEvt[h] = sample > $signed(hiLim[h]);
  end
  for (genvar l = 0; l < NumLo; l++) begin : g_lo
    assign rawEvt[LoBase+l] = sample < $signed(loLim[l]);
  end
  assign rawEvt[CrIdx] = sample > $signed(crossLim);

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  a_r4_sample_hold: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> $stable(sample));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (sample == '0 && !sampleValid));

endmodule

// File: rtl/sd_threshold_filter.sv
module sd_threshold_filter
  import sdcf_pkg::*;
#(
  parameter int AccW  = 18,
  parameter int OsrW  = 5,
  parameter int QualW = 4,
  parameter int NumHi = 2,
  parameter int NumLo = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        modClk,
  input  logic                        modData,
  input  logic [1:0]                  filtType,
  input  logic [OsrW-1:0]             osrCode,
  input  logic [QualW-1:0]            qualCode,
  input  logic [NumHi-1:0][AccW-1:0]  hiLim,
  input  logic [NumLo-1:0][AccW-1:0]  loLim,
  input  logic [AccW-1:0]             crossLim,
  output logic signed [AccW-1:0]      sample,
  output logic                        sampleValid,
  output logic [NumHi-1:0]            overFlag,
  output logic [NumLo-1:0]            underFlag,
  output logic                        crossLevel
);

  localparam int NumEvt = NumHi + NumLo + 1;

  sdcf_stb_t         stb;
  logic [NumEvt-1:0] rawEvt;
  logic [NumEvt-1:0] evtFlag;

  sdcf_ctrl #(.OsrW(OsrW), .QualW(QualW), .NumEvt(NumEvt)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .modClk      (modClk),
    .modData     (modData),
    .osrCode     (osrCode),
    .qualCode    (qualCode),
    .sampleValid (sampleValid),
    .rawEvt      (rawEvt),
    .stb         (stb),
    .evtFlag     (evtFlag)
  );

  sdcf_datapath #(.AccW(AccW), .NumHi(NumHi), .NumLo(NumLo)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .filtType    (filt_e'(filtType)),
    .hiLim       (hiLim),
    .loLim       (loLim),
    .crossLim    (crossLim),
    .sample      (sample),
    .sampleValid (sampleValid),
    .rawEvt      (rawEvt)
  );

  assign overFlag   = evtFlag[NumHi-1:0];
  assign underFlag  = evtFlag[NumHi+NumLo-1:NumHi];
  assign crossLevel = evtFlag[NumEvt-1];

endmodule

// File: tb/tb_sd_threshold_filter.sv
module tb_sd_threshold_filter;

  localparam int AccW = 18;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                      rst = 1'b1;
  logic                      modClk = 1'b0;
  logic                      modData = 1'b0;
  logic [1:0]                filtType = 2'd1;
  logic [4:0]                osrCode = '0;
  logic [3:0]                qualCode = '0;
  logic [1:0][AccW-1:0]      hiLim;
  logic [1:0][AccW-1:0]      loLim;
  logic [AccW-1:0]           crossLim;
  logic signed [AccW-1:0]    sample;
  logic                      sampleValid;
  logic [1:0]                overFlag;
  logic [1:0]                underFlag;
  logic                      crossLevel;

  sd_threshold_filter dut (
    .clk(clk), .rst(rst), .modClk(modClk), .modData(modData),
    .filtType(filtType), .osrCode(osrCode), .qualCode(qualCode),
    .hiLim(hiLim), .loLim(loLim), .crossLim(crossLim),
    .sample(sample), .sampleValid(sampleValid),
    .overFlag(overFlag), .underFlag(underFlag), .crossLevel(crossLevel)
  );

  int    nChk = 0;
  int    nFail = 0;
  string sampTag = "R1";
  int    hist[$];
  int    expQ[$];
  int    expFlag[5];
  int    runLen[5];
  int    osrR = 1, order = 1, gain = 1;
  int    lastSample = 0;
  bit    done = 0;

  task automatic check(string tag, int act, int exp, string what);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference: weighted bits convolved with 'order' boxcars of length osrR
  function automatic int refOut();
    int h[$];
    int t[$];
    int y = 0;
    int n = hist.size() - 1;
    h.push_back(1);
    repeat (order) begin
      t = {};
      for (int k = 0; k < h.size() + osrR - 1; k++) begin
        int s = 0;
        for (int j = 0; j < osrR; j++)
          if (k - j >= 0 && k - j < h.size()) s += h[k-j];
        t.push_back(s);
      end
      h = t;
    end
    for (int j = 0; j < h.size(); j++)
      if (n - j >= 0) y += h[j] * hist[n-j];
    return y * gain;
  endfunction

  function automatic int rawOf(int idx, int v);
    case (idx)
      0, 1: return int'(v > $signed(hiLim[idx]));
      2, 3: return int'(v < $signed(loLim[idx-2]));
      default: return int'(v > $signed(crossLim));
    endcase
  endfunction

  function automatic string flagTag(int idx);
    if (qualCode != 0) return "R8";
    if (idx < 2) return "R5";
    if (idx < 4) return "R6";
    return "R7";
  endfunction

  // monitor: compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      automatic logic [4:0] act = {crossLevel, underFlag, overFlag};
      for (int i = 0; i < 5; i++)
        check(flagTag(i), int'(act[i]), expFlag[i], $sformatf("flag bit %0d", i));
      if (sampleValid) begin
        automatic int v = sample;
        if (expQ.size() == 0) begin
          check("R4", 1, 0, "unexpected sampleValid");
        end else begin
          automatic int e = expQ.pop_front();
          check(sampTag, v, e, "sample value");
        end
        lastSample = v;
        for (int i = 0; i < 5; i++) begin
          automatic int r = rawOf(i, v);
          if (r == expFlag[i]) runLen[i] = 0;
          else begin
            runLen[i]++;
            if (runLen[i] == qualCode + 1) begin
              expFlag[i] = r;
              runLen[i]  = 0;
            end
          end
        end
      end
    end
  end

  task automatic doReset(int ft, int oc, int qc);
    @(negedge clk);
    rst = 1'b1;
    modClk = 1'b0;
    filtType = 2'(ft);
    osrCode  = 5'(oc);
    qualCode = 4'(qc);
    osrR  = oc + 1;
    order = (ft == 0) ? 2 : ft;      // R2
    gain  = (ft == 0) ? 2 : 1;       // R3
    hist = {};
    expQ = {};
    for (int i = 0; i < 5; i++) begin
      expFlag[i] = 0;
      runLen[i]  = 0;
    end
    repeat (3) @(negedge clk);
    // R9: reset state at the ports
    check("R9", int'(sample), 0, "sample in reset");
    check("R9", int'(sampleValid), 0, "valid in reset");
    check("R9", int'({crossLevel, underFlag, overFlag}), 0, "flags in reset");
    rst = 1'b0;
  endtask

  task automatic sendBit(bit b);
    @(negedge clk);
    modData = b;
    repeat (4) @(negedge clk);
    modClk = 1'b1;
    hist.push_back(b ? 1 : -1);
    if (hist.size() % osrR == 0) expQ.push_back(refOut());
    repeat (4) @(negedge clk);
    modClk = 1'b0;
  endtask

  task automatic drain(string tag);
    repeat (8) @(negedge clk);
    check(tag, expQ.size(), 0, "samples still outstanding");
  endtask

  // send one decimation group of 16 bits with k ones (first order: 2k-16)
  task automatic sendGroup(int k);
    for (int j = 0; j < 16; j++) sendBit(j < k);
  endtask

  initial begin
    int oscs[3] = '{0, 4, 31};
    int ks[30] = '{16, 16, 12, 12, 10, 10, 4, 4, 0, 0, 8, 8, 11, 3, 13,
                   13, 2, 2, 2, 6, 6, 6, 14, 14, 14, 9, 9, 9, 7, 1};
    hiLim[0] = 18'(100000); hiLim[1] = 18'(100000);
    loLim[0] = 18'(-100000); loLim[1] = 18'(-100000);
    crossLim = 18'(0);

    // R1 R2 R4: each order at several ratios, random bits
    for (int ft = 1; ft <= 3; ft++) begin
      foreach (oscs[o]) begin
        sampTag = (ft == 1) ? "R1" : "R2";
        doReset(ft, oscs[o], 0);
        for (int b = 0; b < 8 * (oscs[o] + 1); b++) sendBit(1'($urandom_range(0, 1)));
        drain("R4");
      end
    end

    // R3: fast type with doubled weighting
    sampTag = "R3";
    foreach (oscs[o]) begin
      doReset(0, oscs[o], 0);
      for (int b = 0; b < 8 * (oscs[o] + 1); b++) sendBit(($urandom_range(0, 3)) != 0);
      drain("R3");
    end

    // R11: third order extremes at R = 32
    sampTag = "R11";
    doReset(3, 31, 0);
    for (int b = 0; b < 32 * 5; b++) sendBit(1'b1);
    drain("R11");
    check("R11", lastSample, 32768, "full-scale positive");
    for (int b = 0; b < 32 * 5; b++) sendBit(1'b0);
    drain("R11");
    check("R11", lastSample, -32768, "full-scale negative");

    // R5 R6 R7 R8: first order at R = 16, sample = 2k - 16
    hiLim[0] = 18'(8);  hiLim[1] = 18'(0);
    loLim[0] = 18'(-8); loLim[1] = 18'(0);
    crossLim = 18'(4);
    for (int q = 0; q <= 2; q += 2) begin
      sampTag = "R1";
      doReset(1, 15, q);
      foreach (ks[i]) sendGroup(ks[i]);
      drain("R8");
    end
    // R8: longest persistence, 16 samples needed
    doReset(1, 15, 15);
    repeat (15) sendGroup(16);
    drain("R8");
    check("R8", int'(overFlag[0]), 0, "no flag after 15 samples");
    sendGroup(16);
    drain("R8");
    check("R8", int'(overFlag[0]), 1, "flag after 16 samples");
    repeat (16) sendGroup(0);
    drain("R8");
    check("R8", int'(underFlag[0]), 1, "under flag after 16 low samples");

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(10 * 190000);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule